// File: doc/BRIEF.md
# Vectored Interrupt Responder for a Daisy-Chained 8-bit Bus

This block sits inside a peripheral on an 8-bit processor bus and turns an internal event into a vectored interrupt. A rising edge on the peripheral's request line raises an active-low interrupt request toward the processor. The block holds that request as a level, because it has no view of the processor's internal machine cycles. It then waits for the acknowledge cycle, which it recognises when the opcode-fetch strobe and the I/O strobe are both low. During that cycle it places a programmed vector byte on the data bus, but only while the priority chain grants it the bus.

Software selects one of two release policies with a control bit.

- **Auto-release:** the request and the data driver are let go together once both bus strobes have returned high. The device then stays in service until software writes the clear strobe.
- **Level mode:** the request stays asserted after the acknowledge until software clears the source.

In both modes the block keeps the chain output low while it is pending or in service, so devices of lower priority are held off. A single event never produces a second request. A new rising edge that arrives while the device is busy is remembered and raised after the clear.

The bus strobes are asynchronous to the block clock and pass through a synchroniser of `SYNC_STAGES` flops. The priority-chain input is taken as synchronous to the block clock. A two-entry register port holds the vector and the control bits.

Top module: `irqv_responder`

## Requirements
- R1: After reset `int_n` is 1, `dbus_oe` is 0, the vector register is 0x00 and the level-mode bit is 0. `dbus_out` is 0 whenever `dbus_oe` is 0.
- R2: A rising edge of `src_req` sampled at a clock edge drives `int_n` low from that edge. `int_n` stays low whatever `m1_n` and `iorq_n` do until an acknowledge completes or a clear arrives.
- R3: `dbus_oe` goes to 1 with `dbus_out` equal to the vector register at the (SYNC_STAGES+1)-th clock edge after `m1_n` and `iorq_n` are both driven low, provided a request is pending and `iei` is 1.
- R4: `dbus_oe` stays 0 when only `m1_n` is low (opcode fetch), when only `iorq_n` is low, or while `iei` is 0.
- R5: In auto-release mode, `dbus_oe` falls and `int_n` rises at the same edge, the (SYNC_STAGES+1)-th edge after both strobes are driven high again.
- R6: In level mode, `int_n` stays 0 after the acknowledge until a clear write. A further acknowledge in that state drives the vector again.
- R7: A clear write returns a pending, in-service or level-held device to idle, so `int_n` goes to 1 and `ieo` follows `iei`. A clear write while the vector is being driven has no effect.
- R8: `ieo` equals `iei` when the device is idle and is 0 while it is pending, acknowledged, in service or level-held.
- R9: `src_req` held high after a release raises no new request. One rising edge of `src_req` seen while busy is kept and raises `int_n` again right after the clear.
- R10: The register port writes the vector at address 0 (all `VEC_W` bits). At address 1, bit 0 written as 1 is the clear strobe and bit 1 selects the mode (1 = level, 0 = auto-release). Bit 1 is stored on every write to address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 1 | Interrupt event from peripheral logic, rising edge starts a request |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 1 | Register select: 0 vector, 1 control |
| reg_wr_data | input | VEC_W | Register write data |
| m1_n | input | 1 | Opcode-fetch strobe from the bus, active low, asynchronous |
| iorq_n | input | 1 | I/O request strobe from the bus, active low, asynchronous |
| iei | input | 1 | Priority chain enable from the device above |
| ieo | output | 1 | Priority chain enable to the device below |
| int_n | output | 1 | Interrupt request to the processor, active low |
| dbus_out | output | VEC_W | Vector byte toward the data bus |
| dbus_oe | output | 1 | Tri-state enable for the data bus driver |

## Verification
The bench builds the block with `VEC_W` = 8 and `SYNC_STAGES` = 3. The deeper synchroniser makes the acknowledge and release latencies of R3 and R5 differ from the default, so a latency fixed at two stages would show up as a mismatch. A behavioural model with its own strobe-delay queues follows every clock. Directed phases cover both release modes, opcode fetches, a blocked chain input, a clear during the vector drive, a re-acknowledge in level mode, and an edge remembered while busy.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PEND = 3'd1,
        ST_ACK  = 3'd2,
        ST_SERV = 3'd3,
        ST_HOLD = 3'd4
    } irqv_state_e;

    typedef struct packed {
        irqv_state_e state;
        logic        queued;
        logic        req_prev;
        logic        int_n;
        logic        oe;
    } irqv_ctl_t;

    localparam irqv_ctl_t CTL_RESET = '{
        state:    ST_IDLE,
        queued:   1'b0,
        req_prev: 1'b0,
        int_n:    1'b1,
        oe:       1'b0
    };

    localparam int CTL_CLEAR_BIT = 0;
    localparam int CTL_MODE_BIT  = 1;

endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign chain_d[s] = async_in;
            end else begin : g_next
                assign chain_d[s] = chain_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RESET_VAL;
                else        chain_q[s] <= chain_d[s];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irqv_regs.sv
module irqv_regs
    import irqv_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] VEC_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [VEC_W-1:0] wr_data,
    output logic [VEC_W-1:0] vector_q,
    output logic             level_q,
    output logic             clear_pulse
);
    logic [VEC_W-1:0] vector_d;
    logic             level_d;
    logic             wr_vec;
    logic             wr_ctl;

    always_comb begin
        wr_vec      = wr_en && !wr_addr;
        wr_ctl      = wr_en &&  wr_addr;
        vector_d    = vector_q;
        level_d     = level_q;
        clear_pulse = wr_ctl && wr_data[CTL_CLEAR_BIT];
        if (wr_vec) vector_d = wr_data;
        if (wr_ctl) level_d  = wr_data[CTL_MODE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vector_q <= VEC_RESET;
            level_q  <= 1'b0;
        end else begin
            vector_q <= vector_d;
            level_q  <= level_d;
        end
    end
endmodule

// File: rtl/irqv_responder.sv
module irqv_responder
    import irqv_pkg::*;
#(
    parameter int VEC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_req,
    input  logic             reg_wr_en,
    input  logic             reg_wr_addr,
    input  logic [VEC_W-1:0] reg_wr_data,
    input  logic             m1_n,
    input  logic             iorq_n,
    input  logic             iei,
    output logic             ieo,
    output logic             int_n,
    output logic [VEC_W-1:0] dbus_out,
    output logic             dbus_oe
);
    localparam int BUS_W = 2;

    logic [VEC_W-1:0] vector_q;
    logic             level_mode;
    logic             clear_pulse;
    logic [BUS_W-1:0] strobe_sync;
    logic             m1_sync;
    logic             iorq_sync;
    logic             ack_sync;
    logic             bus_idle_sync;
    logic             src_rise;
    logic             start_new;
    logic             clear_ok;

    irqv_ctl_t ctl_d;
    irqv_ctl_t ctl_q;

    irqv_regs #(.VEC_W(VEC_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_addr     (reg_wr_addr),
        .wr_data     (reg_wr_data),
        .vector_q    (vector_q),
        .level_q     (level_mode),
        .clear_pulse (clear_pulse)
    );

    irqv_sync #(.STAGES(SYNC_STAGES), .WIDTH(BUS_W), .RESET_VAL('1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({iorq_n, m1_n}),
        .sync_out (strobe_sync)
    );

    assign m1_sync       = strobe_sync[0];
    assign iorq_sync     = strobe_sync[1];
    assign ack_sync      = !m1_sync && !iorq_sync;
    assign bus_idle_sync =  m1_sync &&  iorq_sync;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.req_prev = src_req;
        src_rise       = src_req && !ctl_q.req_prev;
        start_new      = ctl_q.queued || src_rise;
        clear_ok       = clear_pulse &&
                         (ctl_q.state != ST_IDLE) && (ctl_q.state != ST_ACK);

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (src_rise) ctl_d.state = ST_PEND;
            end
            ST_PEND: begin
                if (clear_pulse)            ctl_d.state = start_new ? ST_PEND : ST_IDLE;
                else if (ack_sync && iei)   ctl_d.state = ST_ACK;
            end
            ST_ACK: begin
                if (bus_idle_sync)          ctl_d.state = level_mode ? ST_HOLD : ST_SERV;
            end
            ST_SERV: begin
                if (clear_pulse)            ctl_d.state = start_new ? ST_PEND : ST_IDLE;
            end
            ST_HOLD: begin
                if (clear_pulse)            ctl_d.state = start_new ? ST_PEND : ST_IDLE;
                else if (ack_sync && iei)   ctl_d.state = ST_ACK;
            end
            default: ctl_d.state = ST_IDLE;
        endcase

        if (src_rise && ctl_q.state != ST_IDLE) ctl_d.queued = 1'b1;
        if (clear_ok)                           ctl_d.queued = 1'b0;

        ctl_d.int_n = !(ctl_d.state inside {ST_PEND, ST_ACK, ST_HOLD});
        ctl_d.oe    = (ctl_d.state == ST_ACK) && ack_sync && iei;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign int_n    = ctl_q.int_n;
    assign dbus_oe  = ctl_q.oe;
    assign dbus_out = ctl_q.oe ? vector_q : '0;
    assign ieo      = iei && (ctl_q.state == ST_IDLE);

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_n,
    input logic             ieo,
    input logic             dbus_oe,
    input logic [VEC_W-1:0] dbus_out,
    input logic             iei,
    input logic             ack_sync,
    input logic             bus_idle_sync,
    input logic             level_mode,
    input logic             clear_pulse,
    input logic             src_rise,
    input logic             queued
);
    AST_OE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> $past(ack_sync && iei));                               // R4

    AST_OE_WITH_INT: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> !int_n);                                                // R3

    AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dbus_oe |-> (dbus_out == '0));                                     // R1

    AST_CHAIN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> !ieo);                                                   // R8

    AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dbus_oe) && $past(!level_mode) && $past(bus_idle_sync)) |-> int_n); // R5

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !int_n && !clear_pulse) |=> !int_n);                 // R6

    AST_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_n && !src_rise && !queued) |=> int_n);                         // R9
endmodule

bind irqv_responder irqv_checker #(.VEC_W(VEC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .int_n         (int_n),
    .ieo           (ieo),
    .dbus_oe       (dbus_oe),
    .dbus_out      (dbus_out),
    .iei           (iei),
    .ack_sync      (ack_sync),
    .bus_idle_sync (bus_idle_sync),
    .level_mode    (level_mode),
    .clear_pulse   (clear_pulse),
    .src_rise      (src_rise),
    .queued        (ctl_q.queued)
);

// File: tb/sim_irqv_responder.sv
`timescale 1ns/1ps
module sim_irqv_responder;
    localparam int W = 8;
    localparam int S = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         src_req = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic         reg_wr_addr = 1'b0;
    logic [W-1:0] reg_wr_data = '0;
    logic         m1_n = 1'b1;
    logic         iorq_n = 1'b1;
    logic         iei = 1'b1;
    logic         ieo;
    logic         int_n;
    logic [W-1:0] dbus_out;
    logic         dbus_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irqv_responder #(.VEC_W(W), .SYNC_STAGES(S)) u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .m1_n(m1_n), .iorq_n(iorq_n), .iei(iei), .ieo(ieo),
        .int_n(int_n), .dbus_out(dbus_out), .dbus_oe(dbus_oe)
    );

    // Reference model: 0 idle, 1 pending, 2 vector out, 3 in service, 4 level held
    bit     q_m1[$];
    bit     q_io[$];
    int     m_st;
    bit     m_queued, m_prev, m_level, m_int_n, m_oe;
    bit [W-1:0] m_vec;

    task automatic model_reset();
        q_m1 = {}; q_io = {};
        for (int i = 0; i < S; i++) begin q_m1.push_back(1'b1); q_io.push_back(1'b1); end
        m_st = 0; m_queued = 0; m_prev = 0; m_level = 0; m_int_n = 1; m_oe = 0; m_vec = '0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            bit m1s, ios, ack, bidle, rise, clr, busy;
            m1s = q_m1.pop_front(); ios = q_io.pop_front();
            q_m1.push_back(m1_n); q_io.push_back(iorq_n);
            ack   = !m1s && !ios;
            bidle =  m1s &&  ios;
            rise  = src_req && !m_prev;
            m_prev = src_req;
            clr   = reg_wr_en && reg_wr_addr && reg_wr_data[0];
            busy  = (m_st != 0);
            if (rise && busy) m_queued = 1;
            if (m_st == 0) begin
                if (rise) m_st = 1;
            end else if (m_st == 2) begin
                if (bidle) m_st = m_level ? 4 : 3;
            end else if (clr) begin
                m_st = m_queued ? 1 : 0;
                m_queued = 0;
            end else if ((m_st == 1 || m_st == 4) && ack && iei) begin
                m_st = 2;
            end
            if (reg_wr_en && !reg_wr_addr) m_vec = reg_wr_data;
            if (reg_wr_en &&  reg_wr_addr) m_level = reg_wr_data[1];
            m_int_n = !(m_st == 1 || m_st == 2 || m_st == 4);
            m_oe    = (m_st == 2) && ack && iei;
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "model int_n", int_n, m_int_n);
            chk("R3", "model dbus_oe", dbus_oe, m_oe);
            chk("R3", "model dbus_out", dbus_out, m_oe ? m_vec : '0);
            chk("R8", "model ieo", ieo, iei && (m_st == 0));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit a, logic [W-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = '0;
    endtask

    task automatic pulse_req();
        src_req = 1'b1; cyc(2); src_req = 1'b0; cyc(1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1'b1;
        report();
    end

    initial begin
        cyc(3);
        chk("R1", "reset int_n", int_n, 1);
        chk("R1", "reset dbus_oe", dbus_oe, 0);
        chk("R1", "reset dbus_out", dbus_out, 0);
        chk("R8", "reset ieo", ieo, 1);
        rst_n = 1'b1;
        cyc(2);

        // auto-release, reset vector
        src_req = 1'b1; cyc(1);
        chk("R2", "int_n after edge", int_n, 0);
        chk("R8", "ieo while pending", ieo, 0);
        m1_n = 1'b0; cyc(6);
        chk("R4", "opcode fetch oe", dbus_oe, 0);
        chk("R2", "int_n during fetch", int_n, 0);
        m1_n = 1'b1; iorq_n = 1'b0; cyc(6);
        chk("R4", "io only oe", dbus_oe, 0);
        iorq_n = 1'b1; cyc(S + 2);
        m1_n = 1'b0; iorq_n = 1'b0; cyc(S);
        chk("R3", "oe before latency", dbus_oe, 0);
        cyc(1);
        chk("R3", "oe at latency", dbus_oe, 1);
        chk("R1", "reset vector driven", dbus_out, 8'h00);
        wr(1'b1, 8'h01);
        chk("R7", "clear during drive ignored", dbus_oe, 1);
        m1_n = 1'b1; iorq_n = 1'b1; cyc(S);
        chk("R5", "oe before release latency", dbus_oe, 1);
        cyc(1);
        chk("R5", "oe released", dbus_oe, 0);
        chk("R5", "int_n released", int_n, 1);
        chk("R8", "ieo in service", ieo, 0);
        cyc(10);
        chk("R9", "held src_req no reassert", int_n, 1);
        wr(1'b1, 8'h01);
        chk("R7", "ieo after clear", ieo, 1);
        cyc(5);
        chk("R9", "held src_req after clear", int_n, 1);
        src_req = 1'b0; cyc(2);

        // chain blocked, then programmed vector
        wr(1'b0, 8'h5A);
        pulse_req();
        iei = 1'b0;
        m1_n = 1'b0; iorq_n = 1'b0; cyc(S + 3);
        chk("R4", "iei low blocks oe", dbus_oe, 0);
        chk("R8", "ieo with iei low", ieo, 0);
        iei = 1'b1; cyc(1);
        chk("R3", "oe after iei high", dbus_oe, 1);
        chk("R10", "vector register value", dbus_out, 8'h5A);
        m1_n = 1'b1; iorq_n = 1'b1; cyc(S + 2);
        chk("R5", "int_n auto release", int_n, 1);
        wr(1'b1, 8'h01);

        // level mode
        wr(1'b1, 8'h02);
        pulse_req();
        m1_n = 1'b0; iorq_n = 1'b0; cyc(S + 2);
        chk("R3", "level mode ack oe", dbus_oe, 1);
        m1_n = 1'b1; iorq_n = 1'b1; cyc(S + 2);
        chk("R6", "level int_n held", int_n, 0);
        chk("R6", "level oe released", dbus_oe, 0);
        cyc(10);
        chk("R10", "level bit keeps int_n", int_n, 0);
        m1_n = 1'b0; iorq_n = 1'b0; cyc(S + 2);
        chk("R6", "re-ack drives vector", dbus_out, 8'h5A);
        m1_n = 1'b1; iorq_n = 1'b1; cyc(S + 2);
        pulse_req();
        wr(1'b1, 8'h03);
        chk("R9", "remembered edge raises int", int_n, 0);
        m1_n = 1'b0; iorq_n = 1'b0; cyc(S + 2);
        m1_n = 1'b1; iorq_n = 1'b1; cyc(S + 2);
        chk("R6", "held before clear", int_n, 0);
        wr(1'b1, 8'h03);
        chk("R7", "level clear releases", int_n, 1);
        chk("R8", "ieo idle again", ieo, 1);

        // cancel while pending, auto mode
        wr(1'b1, 8'h00);
        pulse_req();
        chk("R2", "pending again", int_n, 0);
        wr(1'b1, 8'h01);
        chk("R7", "clear cancels pending", int_n, 1);
        chk("R7", "ieo after cancel", ieo, 1);
        cyc(4);

        done = 1'b1;
        report();
    end
endmodule